// File: doc/BRIEF.md
# Debug Entry Cause Arbiter

This block decides, cycle by cycle, whether a hart leaves normal execution for debug mode and why. Five request sources feed it: a qualified breakpoint instruction, a trigger hit, an external halt request, completion of a single step, and a halt requested straight out of reset. When one or more sources are active while the hart runs, the block picks one winner by a fixed ranking. It then issues a one-cycle entry strobe with the winner's encoded cause and the program counter value that the debug PC register must capture.

A two-state machine tracks the hart. `ST_RUN` is normal execution and `ST_HALTED` is debug mode. The transition ENTER goes from `ST_RUN` to `ST_HALTED` when any qualified source is active. The transition RESUME goes from `ST_HALTED` to `ST_RUN` when `resume` is high. The block also drives counter-inhibit and timer-inhibit signals from two configuration bits. It flags a breakpoint instruction whose privilege level has not enabled debug entry, so that the core traps it as an ordinary exception.

Top module: `dbg_entry_arb`

## Requirements
- R1: After reset `enter_dbg` is 0, `cause` is 0, `in_debug` is 0, and both inhibit outputs are 0.
- R2: Cause codes are 1 breakpoint, 2 trigger, 3 halt request, 4 single step and 5 halt out of reset. When several sources are active, the winner is chosen in this order: trigger, then breakpoint, then reset halt, then halt request, then step.
- R3: A breakpoint counts as a source only if the enable bit for `cur_priv` is set. The encodings are 3 machine (`en_brk_m`), 1 supervisor (`en_brk_s`) and 0 user (`en_brk_u`); code 2 has no enable. Otherwise, while running, `brk_exc` is high and no entry happens for it.
- R4: For a winning breakpoint, `dpc` equals `cur_pc`.
- R5: For a winning halt request or reset halt, `dpc` equals `next_pc`.
- R6: For a winning trigger, `dpc` is `cur_pc` when `trig_timing` is 0 and `next_pc` when it is 1.
- R7: A single step counts only when `step_en` and `step_done` are both high. Its `dpc` is `next_pc`, or `trap_pc` when `step_trap` reports that the stepped instruction faulted. This lets entry happen before the trap handler runs.
- R8: `enter_dbg`, `cause` and `dpc` are registered and appear one cycle after the sources. `in_debug` rises in that same cycle. When no source is active, `enter_dbg` stays 0 and `cause` is 0.
- R9: While `in_debug` is high, no source causes an entry and `brk_exc` is 0. `resume` returns the hart to run one cycle later. `resume` has no effect while running.
- R10: `cnt_inhibit` is high when `stop_count` is set and either the hart is in debug mode or a breakpoint is winning entry in the current cycle.
- R11: `tmr_inhibit` is high exactly when `stop_time` is set and the hart is in debug mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| brk_valid | input | 1 | Breakpoint instruction retiring |
| cur_priv | input | 2 | Current privilege level |
| en_brk_m | input | 1 | Breakpoint enters debug in machine level |
| en_brk_s | input | 1 | Breakpoint enters debug in supervisor level |
| en_brk_u | input | 1 | Breakpoint enters debug in user level |
| trig_hit | input | 1 | Trigger fired |
| trig_timing | input | 1 | Trigger timing: 0 before, 1 after the instruction |
| halt_req | input | 1 | External halt request |
| rst_halt | input | 1 | Halt-out-of-reset request |
| step_en | input | 1 | Step bit set |
| step_done | input | 1 | Stepped instruction completed or faulted |
| step_trap | input | 1 | Stepped instruction faulted |
| resume | input | 1 | Leave debug mode |
| stop_count | input | 1 | Hold counters in debug |
| stop_time | input | 1 | Hold timers in debug |
| cur_pc | input | XLEN | Address of the current instruction |
| next_pc | input | XLEN | Address of the next instruction |
| trap_pc | input | XLEN | Trap handler address |
| enter_dbg | output | 1 | One-cycle entry strobe |
| cause | output | 3 | Encoded entry cause |
| dpc | output | XLEN | PC to capture |
| in_debug | output | 1 | Hart is in debug mode |
| brk_exc | output | 1 | Breakpoint must trap normally |
| cnt_inhibit | output | 1 | Counters held |
| tmr_inhibit | output | 1 | Timers held |

## Verification
`brk_exc` and `cnt_inhibit` are combinational and are due in the same cycle as their inputs. The bench reads them one time step after driving on the falling edge. `enter_dbg`, `cause`, `dpc` and `in_debug` change at the next rising edge, so the bench checks them at the following falling edge against a reference model that it has advanced by one cycle. `tmr_inhibit` follows the mode register, so it is checked in that later slot as well.

// File: rtl/dbg_arb_pkg.sv
package dbg_arb_pkg;
    typedef enum logic [2:0] {
        CAUSE_NONE    = 3'd0,
        CAUSE_BRK     = 3'd1,
        CAUSE_TRIGGER = 3'd2,
        CAUSE_HALTREQ = 3'd3,
        CAUSE_STEP    = 3'd4,
        CAUSE_RSTHALT = 3'd5
    } dbg_cause_e;

    typedef enum logic {
        ST_RUN    = 1'b0,
        ST_HALTED = 1'b1
    } dbg_state_e;

    // Source ranks, 0 is the strongest
    localparam int NUM_SRC   = 5;
    localparam int RK_TRIG   = 0;
    localparam int RK_BRK    = 1;
    localparam int RK_RSTH   = 2;
    localparam int RK_HALT   = 3;
    localparam int RK_STEP   = 4;

    function automatic dbg_cause_e rank_code(input int rk);
        case (rk)
            RK_TRIG: return CAUSE_TRIGGER;
            RK_BRK:  return CAUSE_BRK;
            RK_RSTH: return CAUSE_RSTHALT;
            RK_HALT: return CAUSE_HALTREQ;
            default: return CAUSE_STEP;
        endcase
    endfunction
endpackage

// File: rtl/dbg_brk_qual.sv
module dbg_brk_qual (
    input  logic [1:0] priv,
    input  logic       en_m,
    input  logic       en_s,
    input  logic       en_u,
    output logic       enabled
);
    always_comb begin
        case (priv)
            2'd3:    enabled = en_m;
            2'd1:    enabled = en_s;
            2'd0:    enabled = en_u;
            default: enabled = 1'b0;
        endcase
    end
endmodule

// File: rtl/dbg_cause_prio.sv
module dbg_cause_prio
    import dbg_arb_pkg::*;
(
    input  logic [NUM_SRC-1:0] req,
    output dbg_cause_e         win,
    output logic               any
);
    always_comb begin
        win = CAUSE_NONE;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i]) win = rank_code(i);
        end
    end
    assign any = |req;

    always_comb begin
        a_r2_win_is_top: assert (!(req[RK_TRIG]) || win == CAUSE_TRIGGER);
    end
endmodule

// File: rtl/dbg_pc_sel.sv
module dbg_pc_sel
    import dbg_arb_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  dbg_cause_e        win,
    input  logic              trig_timing,
    input  logic              step_trap,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [XLEN-1:0]   next_pc,
    input  logic [XLEN-1:0]   trap_pc,
    output logic [XLEN-1:0]   pc_out
);
    always_comb begin
        unique case (win)
            CAUSE_BRK:     pc_out = cur_pc;
            CAUSE_TRIGGER: pc_out = trig_timing ? next_pc : cur_pc;
            CAUSE_STEP:    pc_out = step_trap ? trap_pc : next_pc;
            CAUSE_HALTREQ,
            CAUSE_RSTHALT: pc_out = next_pc;
            default:       pc_out = next_pc;
        endcase
    end
endmodule

// File: rtl/dbg_entry_arb.sv
module dbg_entry_arb
    import dbg_arb_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             brk_valid,
    input  logic [1:0]       cur_priv,
    input  logic             en_brk_m,
    input  logic             en_brk_s,
    input  logic             en_brk_u,
    input  logic             trig_hit,
    input  logic             trig_timing,
    input  logic             halt_req,
    input  logic             rst_halt,
    input  logic             step_en,
    input  logic             step_done,
    input  logic             step_trap,
    input  logic             resume,
    input  logic             stop_count,
    input  logic             stop_time,
    input  logic [XLEN-1:0]  cur_pc,
    input  logic [XLEN-1:0]  next_pc,
    input  logic [XLEN-1:0]  trap_pc,
    output logic             enter_dbg,
    output logic [2:0]       cause,
    output logic [XLEN-1:0]  dpc,
    output logic             in_debug,
    output logic             brk_exc,
    output logic             cnt_inhibit,
    output logic             tmr_inhibit
);
    dbg_state_e          state_q, state_d;
    logic                running;
    logic                brk_ok;
    logic [NUM_SRC-1:0]  req;
    dbg_cause_e          win;
    logic                any_req;
    logic [XLEN-1:0]     sel_pc;
    logic                enter_q;
    dbg_cause_e          cause_q;
    logic [XLEN-1:0]     dpc_q;

    assign running = (state_q == ST_RUN);

    dbg_brk_qual u_qual (
        .priv    (cur_priv),
        .en_m    (en_brk_m),
        .en_s    (en_brk_s),
        .en_u    (en_brk_u),
        .enabled (brk_ok)
    );

    always_comb begin
        req           = '0;
        req[RK_TRIG]  = running & trig_hit;
        req[RK_BRK]   = running & brk_valid & brk_ok;
        req[RK_RSTH]  = running & rst_halt;
        req[RK_HALT]  = running & halt_req;
        req[RK_STEP]  = running & step_en & step_done;
    end

    dbg_cause_prio u_prio (
        .req (req),
        .win (win),
        .any (any_req)
    );

    dbg_pc_sel #(.XLEN(XLEN)) u_pcsel (
        .win         (win),
        .trig_timing (trig_timing),
        .step_trap   (step_trap),
        .cur_pc      (cur_pc),
        .next_pc     (next_pc),
        .trap_pc     (trap_pc),
        .pc_out      (sel_pc)
    );

    // Next state: ENTER and RESUME transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:    if (any_req) state_d = ST_HALTED;
            ST_HALTED: if (resume)  state_d = ST_RUN;
            default:   state_d = ST_RUN;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Registered entry outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enter_q <= 1'b0;
            cause_q <= CAUSE_NONE;
            dpc_q   <= '0;
        end else if (running && any_req) begin
            enter_q <= 1'b1;
            cause_q <= win;
            dpc_q   <= sel_pc;
        end else begin
            enter_q <= 1'b0;
            cause_q <= CAUSE_NONE;
        end
    end

    assign enter_dbg   = enter_q;
    assign cause       = cause_q;
    assign dpc         = dpc_q;
    assign in_debug    = (state_q == ST_HALTED);
    assign brk_exc     = running & brk_valid & ~brk_ok;
    assign cnt_inhibit = stop_count & (in_debug | (win == CAUSE_BRK));
    assign tmr_inhibit = stop_time & in_debug;

    a_r8_strobe_cause: assert property (@(posedge clk) disable iff (!rst_n)
        enter_dbg == (cause != 3'd0));
    a_r8_strobe_mode: assert property (@(posedge clk) disable iff (!rst_n)
        enter_dbg |-> in_debug);
    a_r9_no_reentry: assert property (@(posedge clk) disable iff (!rst_n)
        in_debug |=> !enter_dbg);
    a_r2_trigger_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_debug && trig_hit) |=> (cause == 3'd2));
    a_r3_exc_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        brk_exc |-> !req[RK_BRK]);
    a_r11_timer_mode: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_inhibit |-> in_debug);
endmodule

// File: tb/sim_dbg_entry_arb.sv
module sim_dbg_entry_arb;
    localparam int XLEN     = 32;
    localparam int CLK_PER  = 10;
    localparam int WD_LIMIT = 50000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic brk_valid = 0, en_brk_m = 0, en_brk_s = 0, en_brk_u = 0;
    logic [1:0] cur_priv = 2'd3;
    logic trig_hit = 0, trig_timing = 0, halt_req = 0, rst_halt = 0;
    logic step_en = 0, step_done = 0, step_trap = 0, resume = 0;
    logic stop_count = 0, stop_time = 0;
    logic [XLEN-1:0] cur_pc = '0, next_pc = '0, trap_pc = '0;
    logic enter_dbg, in_debug, brk_exc, cnt_inhibit, tmr_inhibit;
    logic [2:0] cause;
    logic [XLEN-1:0] dpc;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    bit m_dbg = 0;
    logic [2:0] e_cause;
    logic [XLEN-1:0] e_dpc;
    bit e_enter;

    always #(CLK_PER/2) clk = ~clk;

    dbg_entry_arb #(.XLEN(XLEN)) u0 (.*);

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic bit brk_en_f();
        case (cur_priv)
            2'd3: return en_brk_m;
            2'd1: return en_brk_s;
            2'd0: return en_brk_u;
            default: return 1'b0;
        endcase
    endfunction

    // Reference: cause and PC from the ranking in R2 and R4-R7
    task automatic model_pick(output logic [2:0] c, output logic [XLEN-1:0] p);
        bit eb;
        eb = brk_valid && brk_en_f();
        c = 3'd0; p = '0;
        if (m_dbg) return;
        if (trig_hit)                    begin c = 3'd2; p = trig_timing ? next_pc : cur_pc; end
        else if (eb)                     begin c = 3'd1; p = cur_pc; end
        else if (rst_halt)               begin c = 3'd5; p = next_pc; end
        else if (halt_req)               begin c = 3'd3; p = next_pc; end
        else if (step_en && step_done)   begin c = 3'd4; p = step_trap ? trap_pc : next_pc; end
    endtask

    // Inputs already driven; check comb outputs, clock, check registered ones
    task automatic run_cycle();
        logic [2:0] c; logic [XLEN-1:0] p;
        #1;
        model_pick(c, p);
        chk("R3 brk_exc", brk_exc, !m_dbg && brk_valid && !brk_en_f());
        chk("R10 cnt_inhibit", cnt_inhibit, stop_count && (m_dbg || c == 3'd1));
        @(posedge clk);
        if (m_dbg) m_dbg = !resume;
        else       m_dbg = (c != 3'd0);
        e_enter = (c != 3'd0);
        e_cause = c;
        if (e_enter) e_dpc = p;
        @(negedge clk);
        chk("R8 enter_dbg", enter_dbg, e_enter);
        chk("R2 cause", cause, e_cause);
        if (e_enter) chk("R4-7 dpc", dpc, e_dpc);
        chk("R9 in_debug", in_debug, m_dbg);
        chk("R11 tmr_inhibit", tmr_inhibit, stop_time && m_dbg);
    endtask

    task automatic clear_src();
        brk_valid = 0; trig_hit = 0; halt_req = 0; rst_halt = 0;
        step_done = 0; step_trap = 0; resume = 0; step_en = 0;
    endtask

    task automatic new_pcs();
        cur_pc  = $urandom & 32'hFFFF_FFFC;
        next_pc = cur_pc + 4;
        trap_pc = 32'h0000_0100 + ($urandom & 32'hF0);
    endtask

    task automatic leave_debug();
        clear_src(); resume = 1; run_cycle(); resume = 0;
    endtask

    initial begin
        int seed;
        seed = 1234;
        void'($urandom(seed));
        #(CLK_PER*2 + 1);
        chk("R1 enter_dbg", enter_dbg, 0);
        chk("R1 cause", cause, 0);
        chk("R1 in_debug", in_debug, 0);
        chk("R1 inhibits", {cnt_inhibit, tmr_inhibit}, 0);
        rst_n = 1;
        @(negedge clk);

        // R2: all sources at once -> trigger
        new_pcs(); en_brk_m = 1; cur_priv = 2'd3;
        brk_valid = 1; trig_hit = 1; halt_req = 1; rst_halt = 1; step_en = 1; step_done = 1;
        run_cycle(); leave_debug();
        // R2/R4: no trigger -> breakpoint, counters held (R10)
        new_pcs(); stop_count = 1;
        brk_valid = 1; halt_req = 1; rst_halt = 1; step_en = 1; step_done = 1;
        run_cycle(); leave_debug(); stop_count = 0;
        // R2/R5: reset halt beats halt request
        new_pcs(); rst_halt = 1; halt_req = 1; step_en = 1; step_done = 1;
        run_cycle(); leave_debug();
        // R5: halt request beats step
        new_pcs(); halt_req = 1; step_en = 1; step_done = 1;
        run_cycle(); leave_debug();
        // R7: faulting step captures trap address
        new_pcs(); step_en = 1; step_done = 1; step_trap = 1;
        run_cycle(); leave_debug();
        // R7: step_done without step_en ignored
        clear_src(); new_pcs(); step_done = 1;
        run_cycle();
        // R6: trigger timing 1
        clear_src(); new_pcs(); trig_hit = 1; trig_timing = 1;
        run_cycle(); leave_debug(); trig_timing = 0;
        // R3: user level disabled, reserved level
        new_pcs(); cur_priv = 2'd0; en_brk_u = 0; brk_valid = 1; run_cycle();
        cur_priv = 2'd2; run_cycle();
        // R9: resume ignored while running, causes ignored in debug
        clear_src(); resume = 1; run_cycle();
        clear_src(); halt_req = 1; stop_time = 1; run_cycle();
        trig_hit = 1; brk_valid = 1; run_cycle(); run_cycle();
        leave_debug(); stop_time = 0;

        // Constrained random mix
        for (int i = 0; i < 3000; i++) begin
            new_pcs();
            cur_priv    = 2'($urandom);
            en_brk_m    = 1'($urandom); en_brk_s = 1'($urandom); en_brk_u = 1'($urandom);
            brk_valid   = ($urandom % 6) == 0;
            trig_hit    = ($urandom % 8) == 0;
            trig_timing = 1'($urandom);
            halt_req    = ($urandom % 7) == 0;
            rst_halt    = ($urandom % 12) == 0;
            step_en     = 1'($urandom);
            step_done   = ($urandom % 3) == 0;
            step_trap   = 1'($urandom);
            resume      = ($urandom % 3) == 0;
            stop_count  = 1'($urandom);
            stop_time   = 1'($urandom);
            run_cycle();
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", WD_LIMIT, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule